// File: doc/BRIEF.md
# Parallel Port Setup Register Block

This block holds the setup state for one high-speed parallel port behind a byte-wide configuration bus. Three register offsets carry live state and a fourth is a reserved hole. From the stored fields the block drives the port's control outputs:

- the combined port enable;
- the direction mode;
- the connector and channel parity enables;
- the fairness enable;
- the diagnostic mode;
- the arbitration level;
- a fixed interrupt level.

It also decodes incoming I/O addresses against the port window chosen by a 2-bit select. The window moves to a different range for DMA cycles when the select is 00.

A sticky, active-low channel-check flag sits at the highest offset. The port pulls it low when it raises a channel check. Software returns it high by writing a 1 to bit 7 of that offset. Writes land on the rising clock edge. Reads are combinational from the bus address.

Top module: `ppcfg_top`

## Requirements
- R1: After reset every writable field is 0 and the check flag `chk_n` is 1. Reads return 0x00 at offsets 0x102, 0x103 and 0x104, and 0x80 at 0x105.
- R2: Offset 0x102 stores the following bits. Reads of 0x102 return bits 7, 6 and 4 as 0. Each bit drives its output directly.
  - bit 5: `diag_mode`
  - bit 3: `conn_par_en`
  - bit 2: `chan_par_en`
  - bit 1: `fair_en`
  - bit 0: enable A
- R3: Offset 0x104 stores the following fields and reads back as written. `arb_level` follows bits 3:0.
  - bit 7: bidirectional disable
  - bits 6:5: window select
  - bit 4: enable B
  - bits 3:0: arbitration level
- R4: `port_en` is 1 only when 0x102 bit 0 and 0x104 bit 4 are both 1.
- R5: Offset 0x103, and any address other than 0x102, 0x104 or 0x105, reads 0. Writes to such addresses change no stored state.
- R6: With DMA low, `io_hit` is 1 when `io_addr` lies inside the window chosen by the select:
  - 00: 0x3BC–0x3BF
  - 01: 0x378–0x37D
  - 10: 0x278–0x27D
  - 11: 0x1378–0x137D
- R7: With `io_dma` high and select 00, the window is 0x1278–0x127D instead. For the other selects, DMA has no effect.
- R8: `io_hit` is 0 whenever `port_en` is 0.
- R9: `bidir_mode` is 1 (bidirectional) when 0x104 bit 7 is 0, and 0 (output-only) when it is 1.
- R10: Behaviour of `chk_n`, each change taking effect on the next rising edge:
  - `chk_event` drives `chk_n` to 0.
  - A write to 0x105 with bit 7 = 1 drives it to 1.
  - A write with bit 7 = 0 leaves it unchanged.
  - When an event and a clearing write arrive in the same cycle, the event wins.
- R11: `irq_level` is always 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the configuration bus |
| bus_addr | input | 12 | Register offset for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| chk_event | input | 1 | Channel check raised by the port |
| io_addr | input | 16 | I/O address to decode |
| io_dma | input | 1 | Current I/O cycle is a DMA cycle |
| io_hit | output | 1 | `io_addr` falls inside the active window |
| port_en | output | 1 | Port enabled |
| bidir_mode | output | 1 | 1 = bidirectional, 0 = output-only |
| conn_par_en | output | 1 | Connector parity check and generate enable |
| chan_par_en | output | 1 | Channel data-parity enable |
| fair_en | output | 1 | Fairness enable |
| diag_mode | output | 1 | Diagnostic mode |
| arb_level | output | 4 | Arbitration level |
| irq_level | output | 4 | Interrupt level (constant 7) |
| chk_n | output | 1 | Active-low channel-check flag |

## Verification
The bench sweeps `io_addr` one below, at, and one above both ends of every window, for each select value and both DMA settings. An off-by-one limit, or a DMA relocation applied to the wrong select, shows up there as a stray or missing hit. It drops each enable bit in turn, so a design that decodes from a single enable would keep hitting. It writes to the reserved offset and to 0x105 with bit 7 at 0, then reads back to catch stray writes. It also fires a check event in the same cycle as a clearing write: a design that gave the clear priority would leave the flag high and lose the check.

// File: rtl/ppcfg_pkg.sv
package ppcfg_pkg;

  localparam int BUS_AW = 12;
  localparam int BUS_DW = 8;

  localparam logic [BUS_AW-1:0] OFS_CTRL  = 12'h102;
  localparam logic [BUS_AW-1:0] OFS_HOLE  = 12'h103;
  localparam logic [BUS_AW-1:0] OFS_SETUP = 12'h104;
  localparam logic [BUS_AW-1:0] OFS_CHK   = 12'h105;

  localparam logic [3:0] IRQ_FIXED = 4'd7;

  typedef struct packed {
    logic diag;
    logic cpar;
    logic dpar;
    logic fair;
    logic en_a;
  } ctrl_t;

  typedef struct packed {
    logic       bid_off;
    logic [1:0] sel;
    logic       en_b;
    logic [3:0] arb;
  } setup_t;

  // Lower bound of the decoded window
  function automatic logic [31:0] win_lo(input logic [1:0] sel, input logic dma);
    logic [31:0] r;
    case (sel)
      2'b00:   r = dma ? 32'h1278 : 32'h03BC;
      2'b01:   r = 32'h0378;
      2'b10:   r = 32'h0278;
      default: r = 32'h1378;
    endcase
    return r;
  endfunction

  // Upper bound of the decoded window (inclusive)
  function automatic logic [31:0] win_hi(input logic [1:0] sel, input logic dma);
    logic [31:0] r;
    case (sel)
      2'b00:   r = dma ? 32'h127D : 32'h03BF;
      2'b01:   r = 32'h037D;
      2'b10:   r = 32'h027D;
      default: r = 32'h137D;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] pack_ctrl(input ctrl_t c);
    return {2'b00, c.diag, 1'b0, c.cpar, c.dpar, c.fair, c.en_a};
  endfunction

endpackage

// File: rtl/ppcfg_regs.sv
module ppcfg_regs
  import ppcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic              chk_event,
  output ctrl_t             ctrl_q,
  output setup_t            setup_q,
  output logic              chk_n_q
);

  logic wr_ctrl, wr_setup, chk_clear;

  assign wr_ctrl   = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_setup  = bus_wr && (bus_addr == OFS_SETUP);
  assign chk_clear = bus_wr && (bus_addr == OFS_CHK) && bus_wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.diag <= bus_wdata[5];
      ctrl_q.cpar <= bus_wdata[3];
      ctrl_q.dpar <= bus_wdata[2];
      ctrl_q.fair <= bus_wdata[1];
      ctrl_q.en_a <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '0;
    end else if (wr_setup) begin
      setup_q <= setup_t'(bus_wdata);
    end
  end

  // Event has priority over a software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         chk_n_q <= 1'b1;
    else if (chk_event) chk_n_q <= 1'b0;
    else if (chk_clear) chk_n_q <= 1'b1;
  end

  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    chk_event |=> !chk_n_q);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_clear && !chk_event) |=> chk_n_q);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_clear && !chk_event) |=> $stable(chk_n_q));
  a_r5_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctrl && !wr_setup) |=> ($stable(ctrl_q) && $stable(setup_q)));

endmodule

// File: rtl/ppcfg_rdmux.sv
module ppcfg_rdmux
  import ppcfg_pkg::*;
(
  input  logic [BUS_AW-1:0] bus_addr,
  input  ctrl_t             ctrl_q,
  input  setup_t            setup_q,
  input  logic              chk_n_q,
  output logic [BUS_DW-1:0] bus_rdata
);

  always_comb begin
    case (bus_addr)
      OFS_CTRL:  bus_rdata = pack_ctrl(ctrl_q);
      OFS_SETUP: bus_rdata = setup_q;
      OFS_CHK:   bus_rdata = {chk_n_q, 7'b0};
      default:   bus_rdata = '0;
    endcase
  end

  always_comb begin
    a_r5_hole_zero: assert (bus_addr != OFS_HOLE || bus_rdata == '0);
  end

endmodule

// File: rtl/ppcfg_win_dec.sv
module ppcfg_win_dec
  import ppcfg_pkg::*;
#(
  parameter int IO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IO_W-1:0] io_addr,
  input  logic            io_dma,
  input  logic [1:0]      sel,
  input  logic            port_en,
  output logic            io_hit
);

  localparam int EXT_W = 32;

  logic [EXT_W-1:0] addr_x, lo, hi;
  logic             in_win;

  assign addr_x = EXT_W'(io_addr);
  assign lo     = win_lo(sel, io_dma);
  assign hi     = win_hi(sel, io_dma);
  assign in_win = (addr_x >= lo) && (addr_x <= hi);
  assign io_hit = port_en && in_win;

  a_r8_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> port_en);
  a_r6_hit_in_span: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> (addr_x >= 32'h0278 && addr_x <= 32'h137D));

endmodule

// File: rtl/ppcfg_top.sv
module ppcfg_top
  import ppcfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        chk_event,
  input  logic [15:0] io_addr,
  input  logic        io_dma,
  output logic        io_hit,
  output logic        port_en,
  output logic        bidir_mode,
  output logic        conn_par_en,
  output logic        chan_par_en,
  output logic        fair_en,
  output logic        diag_mode,
  output logic [3:0]  arb_level,
  output logic [3:0]  irq_level,
  output logic        chk_n
);

  ctrl_t  ctrl_q;
  setup_t setup_q;

  ppcfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .chk_event(chk_event),
    .ctrl_q(ctrl_q), .setup_q(setup_q), .chk_n_q(chk_n)
  );

  ppcfg_rdmux u_rd (
    .bus_addr(bus_addr), .ctrl_q(ctrl_q), .setup_q(setup_q),
    .chk_n_q(chk_n), .bus_rdata(bus_rdata)
  );

  assign port_en     = ctrl_q.en_a & setup_q.en_b;
  assign bidir_mode  = ~setup_q.bid_off;
  assign conn_par_en = ctrl_q.cpar;
  assign chan_par_en = ctrl_q.dpar;
  assign fair_en     = ctrl_q.fair;
  assign diag_mode   = ctrl_q.diag;
  assign arb_level   = setup_q.arb;
  assign irq_level   = IRQ_FIXED;

  ppcfg_win_dec #(.IO_W(16)) u_dec (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_dma(io_dma),
    .sel(setup_q.sel), .port_en(port_en), .io_hit(io_hit)
  );

  a_r4_enable_from_reads: assert property (@(posedge clk) disable iff (!rst_n)
    port_en |-> (bus_addr != OFS_SETUP || bus_rdata[4]));

endmodule

// File: tb/sim_ppcfg_top.sv
`timescale 1ns/1ps
module sim_ppcfg_top;

  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0;
  logic [11:0] bus_addr = 0;
  logic [7:0]  bus_wdata = 0;
  logic [7:0]  bus_rdata;
  logic        chk_event = 0;
  logic [15:0] io_addr = 0;
  logic        io_dma = 0;
  logic        io_hit, port_en, bidir_mode, conn_par_en, chan_par_en;
  logic        fair_en, diag_mode, chk_n;
  logic [3:0]  arb_level, irq_level;

  int errors = 0, checks = 0;

  // Reference state
  logic [7:0] m102 = 0, m104 = 0;
  logic       mchk = 1;

  always #4 clk = ~clk;  // 125 MHz

  ppcfg_top u0 (.*);

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic bit ref_hit(input logic [15:0] a, input logic dma);
    int base, cnt;
    if (!(m102[0] && m104[4])) return 0;
    case (m104[6:5])
      0: begin base = dma ? 'h1278 : 'h3BC; cnt = dma ? 6 : 4; end
      1: begin base = 'h378; cnt = 6; end
      2: begin base = 'h278; cnt = 6; end
      default: begin base = 'h1378; cnt = 6; end
    endcase
    return (int'(a) - base) >= 0 && (int'(a) - base) < cnt;
  endfunction

  function automatic int ref_rd(input logic [11:0] a);
    if (a == 12'h102) return m102;
    if (a == 12'h104) return m104;
    if (a == 12'h105) return mchk ? 'h80 : 0;
    return 0;
  endfunction

  task automatic cyc(input logic we, input logic [11:0] a, input logic [7:0] d,
                     input logic ev, input logic [15:0] io, input logic dma);
    @(negedge clk);
    bus_wr = we; bus_addr = a; bus_wdata = d; chk_event = ev;
    io_addr = io; io_dma = dma;
    #1;
    chk((a == 12'h102 || a == 12'h104 || a == 12'h105) ? "R2/R3 read" : "R5 read",
        bus_rdata, ref_rd(a));
    chk("R4 port_en", port_en, m102[0] & m104[4]);
    chk(!(m102[0] && m104[4]) ? "R8 hit" : (dma && m104[6:5] == 0) ? "R7 hit" : "R6 hit",
        io_hit, ref_hit(io, dma));
    chk("R9 bidir", bidir_mode, !m104[7]);
    chk("R2 ctrl bits", {diag_mode, conn_par_en, chan_par_en, fair_en},
        {m102[5], m102[3], m102[2], m102[1]});
    chk("R3 arb", arb_level, m104[3:0]);
    chk("R10 chk_n", chk_n, mchk);
    chk("R11 irq", irq_level, 7);
    @(posedge clk);
    if (we && a == 12'h102) m102 = d & 8'h2F;
    if (we && a == 12'h104) m104 = d;
    if (ev) mchk = 0;
    else if (we && a == 12'h105 && d[7]) mchk = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] probes [20] = '{16'h3BB, 16'h3BC, 16'h3BF, 16'h3C0, 16'h377, 16'h378,
      16'h37D, 16'h37E, 16'h277, 16'h278, 16'h27D, 16'h27E, 16'h1377, 16'h1378,
      16'h137D, 16'h137E, 16'h1277, 16'h1278, 16'h127D, 16'h127E};
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1 reset state at every offset
    for (int a = 'h101; a <= 'h106; a++) cyc(0, 12'(a), 0, 0, 16'h3BC, 0);
    chk("R1 chk_n reset", chk_n, 1);
    // R2 reserved bits masked
    cyc(1, 12'h102, 8'hFF, 0, 0, 0);
    cyc(0, 12'h102, 0, 0, 0, 0);
    cyc(1, 12'h102, 8'h01, 0, 16'h3BC, 0);
    // R5 writes to the hole and other offsets ignored
    cyc(1, 12'h103, 8'hFF, 0, 0, 0);
    cyc(1, 12'h106, 8'hFF, 0, 0, 0);
    cyc(0, 12'h104, 0, 0, 0, 0);
    cyc(0, 12'h102, 0, 0, 0, 0);
    // R6/R7 window sweep for each select, both DMA settings
    for (int s = 0; s < 4; s++) begin
      cyc(1, 12'h104, 8'(8'h10 | (s << 5) | s), 0, 0, 0);
      for (int p = 0; p < 20; p++)
        for (int m = 0; m < 2; m++) cyc(0, 12'h104, 0, 0, probes[p], 1'(m));
    end
    // R8 each enable dropped in turn
    cyc(1, 12'h102, 8'h00, 0, 16'h1378, 0);
    cyc(0, 12'h104, 0, 0, 16'h1378, 0);
    cyc(1, 12'h102, 8'h2F, 0, 16'h1378, 0);
    cyc(1, 12'h104, 8'h6A, 0, 16'h1378, 0);
    cyc(0, 12'h104, 0, 0, 16'h1378, 0);
    // R9 output-only mode, R3 readback
    cyc(1, 12'h104, 8'hDC, 0, 16'h27A, 0);
    cyc(0, 12'h104, 0, 0, 16'h27A, 0);
    cyc(1, 12'h104, 8'h5C, 0, 16'h27A, 0);
    // R10 check flag sequence
    cyc(0, 12'h105, 0, 1, 0, 0);
    cyc(1, 12'h105, 8'h7F, 0, 0, 0);
    cyc(0, 12'h105, 0, 0, 0, 0);
    cyc(1, 12'h105, 8'h80, 0, 0, 0);
    cyc(0, 12'h105, 0, 0, 0, 0);
    cyc(1, 12'h105, 8'h80, 1, 0, 0);
    cyc(0, 12'h105, 0, 0, 0, 0);
    cyc(1, 12'h105, 8'hFF, 0, 0, 0);
    cyc(0, 12'h105, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule